// File: doc/BRIEF.md
# Inbound Write Ordering Gate

This block sits between the inbound posted-write path and a coherent fabric. It decides, write by write, whether a write may be issued now or must wait. It keeps a count of issued writes that the fabric has not yet reported as globally observed. The count goes up on each issue and down on each observation pulse. A write that needs all earlier writes drained is held until the count reaches zero. Writes on the first virtual channel follow their effective relaxed-ordering attribute. A global override can force that attribute to zero. Writes on the second virtual channel follow a programmable 2-bit ordering mode. The remaining channels are not ordered.

The ordering configuration sits in a small register that loads on a write strobe. It holds the RO override and the second-channel mode. One input port carries a single stream of writes, so writes leave in the order they arrive. A write that may go is issued in the same cycle it is accepted. Its attributes are passed through, with the RO bit replaced by its effective value.

Top module: `wr_order_gate`

## Requirements
- R1: After reset the RO override is 1, the second-channel mode is 01 and the pending count is 0, so the first write of any channel is accepted at once.
- R2: The pending count rises by one on each issue and falls by one on each `go_pulse`. An issue and a pulse in the same cycle leave it unchanged. It never exceeds `MAX_OUT`, and while it equals `MAX_OUT` `in_ready` is low for every write.
- R3: With mode 01, a write with `in_vc`=1 is accepted only when the pending count is 0, so at most one such write is ever outstanding.
- R4: Mode 00 orders `in_vc`=1 writes exactly as mode 01 does.
- R5: With mode 10, an `in_vc`=1 write whose tag equals `DRAIN_TAG` (0x21 by default) waits for a pending count of 0. Any other tag is accepted while the count is below `MAX_OUT`.
- R6: With mode 11, an `in_vc`=1 write with effective RO 1 is accepted without waiting. One with effective RO 0 waits for a pending count of 0.
- R7: Effective RO is `in_ro` AND NOT `in_snoop`. It is forced to 0 for `in_vc`=0 while the override is 1. An `in_vc`=0 write with effective RO 0 waits for a pending count of 0.
- R8: While the override is 0, an `in_vc`=0 non-snooped write with `in_ro`=1 is accepted without waiting and issues with `iss_ro`=1. A snooped one behaves as RO 0.
- R9: Writes with `in_vc` of 2 or 3 are accepted whenever the pending count is below `MAX_OUT`, whatever the configuration. The override does not change their `iss_ro`.
- R10: `iss_valid` is high in exactly the cycles where `in_valid` and `in_ready` are both high. In those cycles `iss_vc` and `iss_tag` equal the inputs and `iss_ro` is the effective RO.
- R11: A configuration written with `cfg_we` in one cycle governs acceptance from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the ordering configuration |
| cfg_ro_ovr | input | 1 | New RO override value (1 forces RO 0 on channel 0) |
| cfg_vc1_mode | input | 2 | New second-channel ordering mode |
| in_valid | input | 1 | Inbound write present |
| in_ready | output | 1 | Gate accepts the present write this cycle |
| in_vc | input | 2 | Virtual channel of the write |
| in_ro | input | 1 | Relaxed-ordering attribute of the write |
| in_snoop | input | 1 | Write is snooped |
| in_tag | input | TAG_W | Transaction tag |
| iss_valid | output | 1 | Write is issued to the fabric this cycle |
| iss_vc | output | 2 | Channel of the issued write |
| iss_ro | output | 1 | Effective RO of the issued write |
| iss_tag | output | TAG_W | Tag of the issued write |
| go_pulse | input | 1 | One earlier issued write became globally observed |

## Verification
If the pending count drifted, it would show at `in_ready` on the very next write that needs a drain. Such a write would be released too early, or stay blocked after the last observation pulse. Filling to `MAX_OUT` makes an off-by-one visible within one write. A wrongly decoded mode or override shows in the same cycle the write is presented. It is either a wrong `in_ready` or a wrong `iss_ro` on the issued write. A configuration load that lands a cycle early or late shows as a ready change one cycle away from the expected edge.

// File: rtl/wog_pkg.sv
`timescale 1ns/100ps
// Shared types of the inbound write ordering gate.
// Assumes two-bit mode encoding; the codes are behaviour and must not move.
package wog_pkg;
    typedef enum logic [1:0] {
        VC1M_RSVD     = 2'b00,
        VC1M_SERIAL   = 2'b01,
        VC1M_TAGDRAIN = 2'b10,
        VC1M_BYRO     = 2'b11
    } vc1_mode_e;

    typedef struct packed {
        logic      ro_ovr;
        vc1_mode_e vc1_mode;
    } gate_cfg_t;

    localparam int VC_W = 2;
    localparam logic [VC_W-1:0] VC_ZERO = 2'd0;
    localparam logic [VC_W-1:0] VC_ONE  = 2'd1;
endpackage

// File: rtl/wog_cfg_reg.sv
`timescale 1ns/100ps
// Holds the ordering configuration.
// Loads on cfg_we and takes effect the following cycle.
// Assumes the strobe is only pulsed while no ordering-sensitive traffic is in flight.
module wog_cfg_reg
    import wog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_ro_ovr,
    input  logic [1:0] cfg_vc1_mode,
    output gate_cfg_t  cfg
);
    // Configuration storage with the documented reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.ro_ovr   <= 1'b1;
            cfg.vc1_mode <= VC1M_SERIAL;
        end else if (cfg_we) begin
            cfg.ro_ovr   <= cfg_ro_ovr;
            cfg.vc1_mode <= vc1_mode_e'(cfg_vc1_mode);
        end
    end

    a_r1_reset_cfg: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg.ro_ovr && cfg.vc1_mode == VC1M_SERIAL));
endmodule

// File: rtl/wog_pending_ctr.sv
`timescale 1ns/100ps
// Counts issued writes that are not yet globally observed.
// Assumes the caller never increments when full.
// A pulse with nothing pending is dropped.
module wog_pending_ctr #(
    parameter int MAX_OUT = 15,
    localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             empty,
    output logic             full
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);
    logic dec_ok;

    // Drop an observation pulse that has nothing to retire.
    always_comb dec_ok = dec && (cnt != '0);

    // Up/down pending counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case ({inc, dec_ok})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Derived flags for the ordering rule.
    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == CNT_MAX);
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> cnt == $past(cnt) + CNT_W'(1));
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt));
endmodule

// File: rtl/wog_order_rule.sv
`timescale 1ns/100ps
// Combinational ordering decision for the write at the input.
// Works out the effective RO and whether the write needs a full drain first.
// Assumes the pending counter supplies its empty and full flags.
module wog_order_rule
    import wog_pkg::*;
#(
    parameter int               TAG_W     = 8,
    parameter logic [TAG_W-1:0] DRAIN_TAG = 'h21
) (
    input  gate_cfg_t        cfg,
    input  logic [VC_W-1:0]  vc,
    input  logic             ro,
    input  logic             snoop,
    input  logic [TAG_W-1:0] tag,
    input  logic             empty,
    input  logic             full,
    output logic             eff_ro,
    output logic             may_go
);
    logic need_drain;

    // Effective RO: snooped writes ignore it, the override clears it on channel 0.
    always_comb eff_ro = ro && !snoop && !((vc == VC_ZERO) && cfg.ro_ovr);

    // Per-channel rule on whether all earlier writes must be observed first.
    always_comb begin
        if (vc == VC_ZERO) begin
            need_drain = !eff_ro;
        end else if (vc == VC_ONE) begin
            case (cfg.vc1_mode)
                VC1M_RSVD, VC1M_SERIAL: need_drain = 1'b1;
                VC1M_TAGDRAIN:          need_drain = (tag == DRAIN_TAG);
                VC1M_BYRO:              need_drain = !eff_ro;
                default:                need_drain = 1'b1;
            endcase
        end else begin
            need_drain = 1'b0;
        end
    end

    // Release when there is room and the drain condition, if any, holds.
    always_comb may_go = !full && (!need_drain || empty);
endmodule

// File: rtl/wr_order_gate.sv
`timescale 1ns/100ps
// Inbound write ordering gate, top level.
// Issues each inbound posted write in the cycle it is accepted.
// It holds a write back until its channel's ordering rule is met.
// Assumes one go_pulse per issued write and a single in-order input stream.
module wr_order_gate
    import wog_pkg::*;
#(
    parameter int               TAG_W     = 8,
    parameter logic [TAG_W-1:0] DRAIN_TAG = 'h21,
    parameter int               MAX_OUT   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_ro_ovr,
    input  logic [1:0]       cfg_vc1_mode,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_vc,
    input  logic             in_ro,
    input  logic             in_snoop,
    input  logic [TAG_W-1:0] in_tag,
    output logic             iss_valid,
    output logic [1:0]       iss_vc,
    output logic             iss_ro,
    output logic [TAG_W-1:0] iss_tag,
    input  logic             go_pulse
);
    localparam int CNT_W = $clog2(MAX_OUT + 1);

    gate_cfg_t        cfg;
    logic [CNT_W-1:0] pend_cnt;
    logic             pend_empty;
    logic             pend_full;
    logic             eff_ro;
    logic             may_go;

    wog_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_ro_ovr   (cfg_ro_ovr),
        .cfg_vc1_mode (cfg_vc1_mode),
        .cfg          (cfg)
    );

    wog_order_rule #(.TAG_W(TAG_W), .DRAIN_TAG(DRAIN_TAG)) u_rule (
        .cfg    (cfg),
        .vc     (in_vc),
        .ro     (in_ro),
        .snoop  (in_snoop),
        .tag    (in_tag),
        .empty  (pend_empty),
        .full   (pend_full),
        .eff_ro (eff_ro),
        .may_go (may_go)
    );

    wog_pending_ctr #(.MAX_OUT(MAX_OUT)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (iss_valid),
        .dec   (go_pulse),
        .cnt   (pend_cnt),
        .empty (pend_empty),
        .full  (pend_full)
    );

    // Handshake and pass-through of the issued write.
    always_comb begin
        in_ready  = may_go;
        iss_valid = in_valid && may_go;
        iss_vc    = in_vc;
        iss_tag   = in_tag;
        iss_ro    = eff_ro;
    end

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == CNT_W'(MAX_OUT)) |-> !in_ready);
    a_r3_serial_single: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vc == VC_ONE && !cfg.vc1_mode[1] && pend_cnt != '0) |-> !in_ready);
    a_r7_override_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && in_vc == VC_ZERO && cfg.ro_ovr) |-> !iss_ro);
    a_r5_drain_tag_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && in_vc == VC_ONE && cfg.vc1_mode == VC1M_TAGDRAIN
         && in_tag == DRAIN_TAG) |-> pend_cnt == '0);
endmodule

// File: tb/wr_order_gate_bench.sv
`timescale 1ns/100ps
module wr_order_gate_bench;
    localparam int MAXO = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_ro_ovr = 1'b0;
    logic [1:0] cfg_vc1_mode = 2'b00;
    logic       in_valid = 1'b0, in_ro = 1'b0, in_snoop = 1'b0, go_pulse = 1'b0;
    logic [1:0] in_vc = 2'd0;
    logic [7:0] in_tag = 8'd0;
    logic       in_ready, iss_valid, iss_ro;
    logic [1:0] iss_vc;
    logic [7:0] iss_tag;

    int n_chk = 0, n_bad = 0, mcnt = 0;
    logic       cur_ovr = 1'b1;
    logic [1:0] cur_mode = 2'b01;
    bit done = 0;

    always #2.5 clk = ~clk;

    wr_order_gate u_wr_order_gate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ro_ovr(cfg_ro_ovr),
        .cfg_vc1_mode(cfg_vc1_mode), .in_valid(in_valid), .in_ready(in_ready),
        .in_vc(in_vc), .in_ro(in_ro), .in_snoop(in_snoop), .in_tag(in_tag),
        .iss_valid(iss_valid), .iss_vc(iss_vc), .iss_ro(iss_ro), .iss_tag(iss_tag),
        .go_pulse(go_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic f_effro(logic [1:0] vc, logic ro, logic sn, logic ovr);
        return ro && !sn && !(vc == 2'd0 && ovr);
    endfunction

    function automatic logic f_ready(logic [1:0] mode, logic ovr, logic [1:0] vc,
                                     logic ro, logic sn, logic [7:0] tag, int cnt);
        logic er;
        er = f_effro(vc, ro, sn, ovr);
        if (cnt >= MAXO) return 1'b0;
        if (vc == 2'd0) return er || cnt == 0;
        if (vc == 2'd1) begin
            if (mode == 2'b10) return (tag != 8'h21) || cnt == 0;
            if (mode == 2'b11) return er || cnt == 0;
            return cnt == 0;
        end
        return 1'b1;
    endfunction

    task automatic set_cfg(input logic ovr, input logic [1:0] mode);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ro_ovr = ovr; cfg_vc1_mode = mode;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_ovr = ovr; cur_mode = mode;
    endtask

    task automatic go_once();
        @(negedge clk);
        go_pulse = 1'b1;
        @(negedge clk);
        go_pulse = 1'b0;
        mcnt--;
    endtask

    task automatic drain();
        while (mcnt > 0) go_once();
    endtask

    task automatic filler(input string req);
        @(negedge clk);
        in_valid = 1'b1; in_vc = 2'd2; in_ro = 1'b0; in_snoop = 1'b0; in_tag = 8'h00;
        #1 chk(req, in_ready, (mcnt < MAXO));
        @(negedge clk);
        in_valid = 1'b0;
        if (mcnt < MAXO) mcnt++;
    endtask

    // Present one write; if held, retire one pending write and expect release.
    task automatic try_write(input string req, input logic [1:0] vc, input logic ro,
                             input logic sn, input logic [7:0] tag);
        logic e, er;
        @(negedge clk);
        in_valid = 1'b1; in_vc = vc; in_ro = ro; in_snoop = sn; in_tag = tag;
        er = f_effro(vc, ro, sn, cur_ovr);
        e  = f_ready(cur_mode, cur_ovr, vc, ro, sn, tag, mcnt);
        #1;
        chk(req, in_ready, e);
        chk({req, " R10"}, iss_valid, e);
        if (!e) begin
            go_pulse = 1'b1;
            @(negedge clk);
            go_pulse = 1'b0;
            mcnt--;
            #1;
            chk(req, in_ready, f_ready(cur_mode, cur_ovr, vc, ro, sn, tag, mcnt));
        end
        chk({req, " R10"}, {iss_vc, iss_tag, iss_ro}, {vc, tag, er});
        @(negedge clk);
        in_valid = 1'b0;
        mcnt++;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset configuration is override 1, mode 01.
        try_write("R1", 2'd1, 1'b1, 1'b0, 8'h05);
        try_write("R1", 2'd1, 1'b1, 1'b0, 8'h05);
        try_write("R1", 2'd0, 1'b1, 1'b0, 8'h05);
        drain();

        // Sweep of mode, override, channel, RO, snoop, tag and pending depth.
        for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
                set_cfg(o[0], m[1:0]);
                for (int v = 0; v < 4; v++)
                for (int r = 0; r < 2; r++)
                for (int s = 0; s < 2; s++)
                for (int t = 0; t < 2; t++)
                for (int p = 0; p < 2; p++) begin
                    string req;
                    if (v == 1) req = (m == 0) ? "R4" : (m == 1) ? "R3" : (m == 2) ? "R5" : "R6";
                    else if (v == 0) req = o[0] ? "R7" : "R8";
                    else req = "R9";
                    drain();
                    if (p == 1) filler("R9");
                    try_write(req, v[1:0], r[0], s[0], t[0] ? 8'h21 : 8'h05);
                    drain();
                end
            end
        end

        // R2: fill to the limit, simultaneous issue and pulse, then refill.
        set_cfg(1'b1, 2'b01);
        for (int i = 0; i < MAXO; i++) filler("R2");
        @(negedge clk);
        in_valid = 1'b1; in_vc = 2'd2;
        #1 chk("R2 full", in_ready, 1'b0);
        chk("R2 full", iss_valid, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        go_once();
        @(negedge clk);
        in_valid = 1'b1; go_pulse = 1'b1;
        #1 chk("R2 both", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; go_pulse = 1'b0;
        filler("R2 hold");
        @(negedge clk);
        in_valid = 1'b1; in_vc = 2'd2;
        #1 chk("R2 refull", in_ready, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        drain();

        // R11: configuration change affects the following cycle only.
        filler("R11");
        @(negedge clk);
        in_valid = 1'b1; in_vc = 2'd1; in_ro = 1'b1; in_snoop = 1'b0; in_tag = 8'h05;
        cfg_we = 1'b1; cfg_ro_ovr = 1'b1; cfg_vc1_mode = 2'b11;
        #1 chk("R11 before", in_ready, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0; cur_mode = 2'b11;
        #1 chk("R11 after", in_ready, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        mcnt++;
        drain();

        done = 1;
        report();
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end
endmodule